// File: doc/BRIEF.md
# Dual-Bus Multichannel DMA Controller

This block moves bytes between two buses that share a single 8-bit data path: a general bus with 24-bit addresses and a peripheral register bus with 8-bit addresses. Every byte takes one clock. In that cycle the controller raises a read strobe on one bus and a write strobe on the other, so the byte passes straight from source to sink and is never held inside the controller. The data lines themselves are outside the block. The controller drives only the two addresses and the four strobes.

There are eight channels, and each one is programmed through a narrow configuration write port. A channel in block mode starts when software sets its enable bit. It then streams its whole byte count and disables itself. A channel in scanline mode stays armed. On every rising edge of the horizontal-blank input it fires a short burst of one to four bytes. Scanline bursts take priority over a block transfer in progress. The block transfer is suspended between two bytes and later resumes at the address and count where it stopped.

Top module: `dma_dual_bus`

## Requirements
- R1: Configuration writes (`cfg_we` high for one cycle) select a channel with `cfg_ch` and a field with `cfg_sel`. The field codes are: 0 = general address (24 bits), 1 = peripheral address (8 bits), 2 = byte count (16 bits), 3 = control. Control bits are: bit0 direction, bit1 scanline mode, bits[3:2] burst length minus one, bit4 enable.
- R2: In each move cycle exactly one bus is read and the other is written. Direction 0 reads the general bus and writes the peripheral bus. Direction 1 does the reverse.
- R3: After each byte a channel's general address increments by one, modulo 2^24. Its peripheral address stays fixed.
- R4: Setting enable on a block-mode channel starts it. The channel moves exactly `count` bytes, then clears its own enable and moves nothing more.
- R5: A block-mode count of zero moves 65536 bytes.
- R6: Among pending block-mode channels, the lowest-numbered one is served first. A channel that has started runs to completion before any other block-mode channel moves.
- R7: On a rising edge of `hblank`, every enabled scanline-mode channel moves (burst length + 1) bytes. Channels are served lowest-numbered first, and each finishes its burst before the next starts. Such a channel stays enabled. Its general address carries over between bursts, and its byte count is left unchanged.
- R8: A scanline burst preempts a running block transfer between two bytes. Afterwards the block transfer resumes with no address skipped or repeated and with its full count delivered.
- R9: Only a rising edge of `hblank` triggers bursts. An edge that arrives while any burst is still outstanding is ignored.
- R10: `busy` is high exactly in the cycles in which a byte moves, and `act_ch` then names the moving channel. When `busy` is low, all four strobes are low.
- R11: After reset every channel is disabled. `busy` and all strobes are low, and an `hblank` edge causes no movement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_ch | input | 3 | Channel addressed by the write |
| cfg_sel | input | 2 | Field code (see R1) |
| cfg_wdata | input | 24 | Write data, low bits used for narrower fields |
| hblank | input | 1 | Horizontal-blank indication, rising edge triggers bursts |
| ga_addr | output | 24 | General bus address |
| ga_rd | output | 1 | General bus read strobe |
| ga_wr | output | 1 | General bus write strobe |
| pa_addr | output | 8 | Peripheral bus address |
| pa_rd | output | 1 | Peripheral bus read strobe |
| pa_wr | output | 1 | Peripheral bus write strobe |
| busy | output | 1 | A byte moves this cycle |
| act_ch | output | 3 | Channel moving this cycle |

## Verification
The assertions check the bus discipline on every cycle. They confirm that one bus is read and the other written while `busy` is high, and that the strobes are quiet otherwise. They also check that consecutive bytes of the same channel step the general address by one and hold the peripheral address. The bench scenarios are needed for the rest: arbitration order, run-to-completion, self-clearing of enable, the 65536-byte zero count, preemption and resumption, and the ignored `hblank` edges. These all depend on the sequence and the number of moves, and the bench checks them against a log of every byte transferred.

// File: rtl/dma_pkg.sv
package dma_pkg;
    parameter int GA_W  = 24;
    parameter int PA_W  = 8;
    parameter int CNT_W = 16;
    parameter int BL_W  = 2;

    localparam int REM_W = BL_W + 1;

    localparam int CTL_DIR  = 0;
    localparam int CTL_HM   = 1;
    localparam int CTL_BL   = 2;
    localparam int CTL_EN   = CTL_BL + BL_W;

    typedef enum logic [1:0] {
        SEL_GADDR = 2'd0,
        SEL_PADDR = 2'd1,
        SEL_COUNT = 2'd2,
        SEL_CTRL  = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [GA_W-1:0]  gaddr;
        logic [PA_W-1:0]  paddr;
        logic [CNT_W-1:0] count;
        logic             dir;
        logic             hmode;
        logic [BL_W-1:0]  blen;
        logic             en;
    } chan_t;
endpackage

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
    parameter int N  = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/dma_bus_drive.sv
module dma_bus_drive (
    input  logic mv,
    input  logic dir,
    output logic ga_rd,
    output logic ga_wr,
    output logic pa_rd,
    output logic pa_wr
);
    always_comb begin
        ga_rd = mv & ~dir;
        pa_wr = mv & ~dir;
        pa_rd = mv &  dir;
        ga_wr = mv &  dir;
    end
endmodule

// File: rtl/dma_dual_bus.sv
module dma_dual_bus
    import dma_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [CW-1:0]   cfg_ch,
    input  logic [1:0]      cfg_sel,
    input  logic [GA_W-1:0] cfg_wdata,
    input  logic            hblank,
    output logic [GA_W-1:0] ga_addr,
    output logic            ga_rd,
    output logic            ga_wr,
    output logic [PA_W-1:0] pa_addr,
    output logic            pa_rd,
    output logic            pa_wr,
    output logic            busy,
    output logic [CW-1:0]   act_ch
);
    typedef struct packed {
        chan_t [NCH-1:0]             ch;
        logic  [NCH-1:0][REM_W-1:0]  rem;
        logic                        gen_lock;
        logic  [CW-1:0]              gen_cur;
        logic                        hb_q;
        logic  [GA_W-1:0]            ga_addr;
        logic  [PA_W-1:0]            pa_addr;
        logic                        ga_rd;
        logic                        ga_wr;
        logic                        pa_rd;
        logic                        pa_wr;
        logic                        busy;
        logic  [CW-1:0]              act;
    } state_t;

    state_t s_q, s_d;

    logic [NCH-1:0] hb_req_d, gen_req_d;
    logic           hb_any_d, gen_any_d;
    logic [CW-1:0]  hb_idx_d, gen_idx_d;
    logic           mv_d, is_hb_d, lock_ok_d, sel_dir_d;
    logic [CW-1:0]  sel_d;
    logic           nx_ga_rd, nx_ga_wr, nx_pa_rd, nx_pa_wr;

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            hb_req_d[i]  = (s_q.rem[i] != '0);
            gen_req_d[i] = s_q.ch[i].en & ~s_q.ch[i].hmode;
        end
    end

    dma_prio_pick #(.N(NCH), .IW(CW)) u_hb_pick (
        .req (hb_req_d),
        .any (hb_any_d),
        .idx (hb_idx_d)
    );

    dma_prio_pick #(.N(NCH), .IW(CW)) u_gen_pick (
        .req (gen_req_d),
        .any (gen_any_d),
        .idx (gen_idx_d)
    );

    always_comb begin
        lock_ok_d = s_q.gen_lock & gen_req_d[s_q.gen_cur];
        mv_d      = 1'b0;
        is_hb_d   = 1'b0;
        sel_d     = '0;
        if (hb_any_d) begin
            mv_d    = 1'b1;
            is_hb_d = 1'b1;
            sel_d   = hb_idx_d;
        end else if (lock_ok_d) begin
            mv_d  = 1'b1;
            sel_d = s_q.gen_cur;
        end else if (gen_any_d) begin
            mv_d  = 1'b1;
            sel_d = gen_idx_d;
        end
        sel_dir_d = s_q.ch[sel_d].dir;
    end

    dma_bus_drive u_drive (
        .mv    (mv_d),
        .dir   (sel_dir_d),
        .ga_rd (nx_ga_rd),
        .ga_wr (nx_ga_wr),
        .pa_rd (nx_pa_rd),
        .pa_wr (nx_pa_wr)
    );

    always_comb begin
        s_d = s_q;

        s_d.hb_q  = hblank;
        s_d.busy  = mv_d;
        s_d.ga_rd = nx_ga_rd;
        s_d.ga_wr = nx_ga_wr;
        s_d.pa_rd = nx_pa_rd;
        s_d.pa_wr = nx_pa_wr;

        if (s_q.gen_lock && !lock_ok_d) begin
            s_d.gen_lock = 1'b0;
        end

        if (mv_d) begin
            s_d.act              = sel_d;
            s_d.ga_addr          = s_q.ch[sel_d].gaddr;
            s_d.pa_addr          = s_q.ch[sel_d].paddr;
            s_d.ch[sel_d].gaddr  = s_q.ch[sel_d].gaddr + 1'b1;
            if (is_hb_d) begin
                s_d.rem[sel_d] = s_q.rem[sel_d] - 1'b1;
            end else begin
                s_d.ch[sel_d].count = s_q.ch[sel_d].count - 1'b1;
                if (s_q.ch[sel_d].count == CNT_W'(1)) begin
                    s_d.ch[sel_d].en = 1'b0;
                    s_d.gen_lock     = 1'b0;
                end else begin
                    s_d.gen_lock = 1'b1;
                    s_d.gen_cur  = sel_d;
                end
            end
        end

        if (hblank && !s_q.hb_q && !hb_any_d) begin
            for (int i = 0; i < NCH; i++) begin
                if (s_q.ch[i].en && s_q.ch[i].hmode) begin
                    s_d.rem[i] = {1'b0, s_q.ch[i].blen} + 1'b1;
                end
            end
        end

        if (cfg_we) begin
            case (cfg_sel_e'(cfg_sel))
                SEL_GADDR: s_d.ch[cfg_ch].gaddr = cfg_wdata;
                SEL_PADDR: s_d.ch[cfg_ch].paddr = cfg_wdata[PA_W-1:0];
                SEL_COUNT: s_d.ch[cfg_ch].count = cfg_wdata[CNT_W-1:0];
                default: begin
                    s_d.ch[cfg_ch].dir   = cfg_wdata[CTL_DIR];
                    s_d.ch[cfg_ch].hmode = cfg_wdata[CTL_HM];
                    s_d.ch[cfg_ch].blen  = cfg_wdata[CTL_BL +: BL_W];
                    s_d.ch[cfg_ch].en    = cfg_wdata[CTL_EN];
                    s_d.rem[cfg_ch]      = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ga_addr = s_q.ga_addr;
    assign ga_rd   = s_q.ga_rd;
    assign ga_wr   = s_q.ga_wr;
    assign pa_addr = s_q.pa_addr;
    assign pa_rd   = s_q.pa_rd;
    assign pa_wr   = s_q.pa_wr;
    assign busy    = s_q.busy;
    assign act_ch  = s_q.act;
endmodule

// File: rtl/dma_checker.sv
module dma_checker
    import dma_pkg::*;
#(
    parameter int CW = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic [GA_W-1:0] ga_addr,
    input logic            ga_rd,
    input logic            ga_wr,
    input logic [PA_W-1:0] pa_addr,
    input logic            pa_rd,
    input logic            pa_wr,
    input logic            busy,
    input logic [CW-1:0]   act_ch
);
    assert_one_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (ga_rd ^ pa_rd));

    assert_one_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (ga_wr ^ pa_wr));

    assert_cross_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (ga_rd == pa_wr));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(ga_rd || ga_wr || pa_rd || pa_wr));

    assert_ga_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && act_ch == $past(act_ch))
            |-> (ga_addr == $past(ga_addr) + 1'b1));

    assert_pa_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && act_ch == $past(act_ch))
            |-> (pa_addr == $past(pa_addr)));
endmodule

bind dma_dual_bus dma_checker #(.CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ga_addr (ga_addr),
    .ga_rd   (ga_rd),
    .ga_wr   (ga_wr),
    .pa_addr (pa_addr),
    .pa_rd   (pa_rd),
    .pa_wr   (pa_wr),
    .busy    (busy),
    .act_ch  (act_ch)
);

// File: tb/dma_dual_bus_tb.sv
module dma_dual_bus_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_ch = '0;
    logic [1:0]  cfg_sel = '0;
    logic [23:0] cfg_wdata = '0;
    logic        hblank = 1'b0;
    logic [23:0] ga_addr;
    logic        ga_rd, ga_wr, pa_rd, pa_wr, busy;
    logic [7:0]  pa_addr;
    logic [2:0]  act_ch;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    dma_dual_bus u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .hblank(hblank),
        .ga_addr(ga_addr), .ga_rd(ga_rd), .ga_wr(ga_wr),
        .pa_addr(pa_addr), .pa_rd(pa_rd), .pa_wr(pa_wr),
        .busy(busy), .act_ch(act_ch)
    );

    // move log, written only here
    int          log_n = 0;
    logic [23:0] last_ga;
    logic [2:0]  l_ch [0:1023];
    logic [23:0] l_ga [0:1023];
    logic [7:0]  l_pa [0:1023];
    logic [3:0]  l_st [0:1023];   // {ga_rd, ga_wr, pa_rd, pa_wr}

    always @(negedge clk) begin
        if (rst_n && busy) begin
            if (log_n < 1024) begin
                l_ch[log_n] = act_ch;
                l_ga[log_n] = ga_addr;
                l_pa[log_n] = pa_addr;
                l_st[log_n] = {ga_rd, ga_wr, pa_rd, pa_wr};
            end
            last_ga = ga_addr;
            log_n = log_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] ctl(input bit dir, input bit hm,
                                        input int bl, input bit en);
        return 24'((int'(en) << 4) | (bl << 2) | (int'(hm) << 1) | int'(dir));
    endfunction

    // call at a negedge; returns at the next negedge
    task automatic wr(input int ch, input int sel, input logic [23:0] d);
        cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_sel = 2'(sel); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(input int ch, input logic [23:0] ga, input logic [7:0] pa,
                         input int cnt);
        wr(ch, 0, ga);
        wr(ch, 1, {16'h0, pa});
        wr(ch, 2, 24'(cnt));
    endtask

    task automatic wait_idle();
        int q = 0;
        while (q < 6) begin
            @(negedge clk);
            if (busy) q = 0; else q++;
        end
    endtask

    task automatic pulse_hb(input int hi);
        hblank = 1'b1;
        repeat (hi) @(negedge clk);
        hblank = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_run(input int base, input int n, input int ch,
                             input logic [23:0] ga0, input logic [7:0] pa,
                             input bit dir, input string req);
        for (int i = 0; i < n; i++) begin
            chk(l_ch[base+i] == 3'(ch), req, "channel", l_ch[base+i], ch);
            chk(l_ga[base+i] == ga0 + 24'(i), "R3", "general addr", l_ga[base+i], ga0 + 24'(i));
            chk(l_pa[base+i] == pa, "R3", "periph addr", l_pa[base+i], pa);
            chk(l_st[base+i] == (dir ? 4'b0110 : 4'b1001), "R2", "strobes",
                l_st[base+i], dir ? 4'b0110 : 4'b1001);
        end
    endtask

    task automatic t_reset();
        int b;
        chk(busy == 1'b0, "R11", "busy after reset", busy, 0);
        chk({ga_rd, ga_wr, pa_rd, pa_wr} == 4'b0, "R11", "strobes after reset",
            {ga_rd, ga_wr, pa_rd, pa_wr}, 0);
        b = log_n;
        pulse_hb(1);
        repeat (10) @(negedge clk);
        chk(log_n == b, "R11", "moves with channels disabled", log_n - b, 0);
    endtask

    task automatic t_basic();
        int b;
        setup(2, 24'h123400, 8'h18, 5);
        b = log_n;
        wr(2, 3, ctl(0, 0, 0, 1));
        wait_idle();
        chk(log_n - b == 5, "R4", "block byte count", log_n - b, 5);
        check_run(b, 5, 2, 24'h123400, 8'h18, 0, "R1");
        repeat (20) @(negedge clk);
        chk(log_n - b == 5, "R4", "no moves after enable self-clear", log_n - b, 5);
        chk(busy == 1'b0, "R10", "busy low when done", busy, 0);
    endtask

    task automatic t_dir_wrap();
        int b;
        setup(7, 24'hFFFFFE, 8'hA5, 3);
        b = log_n;
        wr(7, 3, ctl(1, 0, 0, 1));
        wait_idle();
        chk(log_n - b == 3, "R4", "dir1 byte count", log_n - b, 3);
        check_run(b, 3, 7, 24'hFFFFFE, 8'hA5, 1, "R2");
        chk(l_ga[b+2] == 24'h000000, "R3", "address wraps", l_ga[b+2], 0);
    endtask

    task automatic t_prio();
        int b;
        setup(6, 24'h000600, 8'h06, 6);
        setup(4, 24'h000400, 8'h04, 2);
        setup(1, 24'h000100, 8'h01, 2);
        b = log_n;
        wr(6, 3, ctl(0, 0, 0, 1));
        wr(4, 3, ctl(0, 0, 0, 1));
        wr(1, 3, ctl(0, 0, 0, 1));
        wait_idle();
        chk(log_n - b == 10, "R6", "total bytes", log_n - b, 10);
        check_run(b,     6, 6, 24'h000600, 8'h06, 0, "R6");
        check_run(b + 6, 2, 1, 24'h000100, 8'h01, 0, "R6");
        check_run(b + 8, 2, 4, 24'h000400, 8'h04, 0, "R6");
    endtask

    task automatic t_hblank();
        int b;
        setup(0, 24'h003000, 8'h40, 7);
        setup(3, 24'h003100, 8'h43, 7);
        wr(0, 3, ctl(0, 1, 3, 1));
        wr(3, 3, ctl(1, 1, 0, 1));
        repeat (5) @(negedge clk);
        chk(busy == 1'b0, "R7", "armed channels idle before edge", busy, 0);
        b = log_n;
        pulse_hb(1);
        wait_idle();
        chk(log_n - b == 5, "R7", "first burst bytes", log_n - b, 5);
        check_run(b,     4, 0, 24'h003000, 8'h40, 0, "R7");
        check_run(b + 4, 1, 3, 24'h003100, 8'h43, 1, "R7");
        b = log_n;
        pulse_hb(1);
        wait_idle();
        chk(log_n - b == 5, "R7", "second burst bytes", log_n - b, 5);
        check_run(b,     4, 0, 24'h003004, 8'h40, 0, "R7");
        check_run(b + 4, 1, 3, 24'h003101, 8'h43, 1, "R7");
        // count untouched: switch ch3 to block mode, expect 7 bytes
        b = log_n;
        wr(3, 3, ctl(1, 0, 0, 1));
        wait_idle();
        chk(log_n - b == 7, "R7", "count unchanged by bursts", log_n - b, 7);
        check_run(b, 7, 3, 24'h003102, 8'h43, 1, "R7");
        wr(0, 3, ctl(0, 0, 0, 0));
    endtask

    task automatic t_ignore();
        int b;
        setup(0, 24'h002000, 8'h20, 1);
        wr(0, 3, ctl(0, 1, 3, 1));
        b = log_n;
        hblank = 1'b1; @(negedge clk);
        hblank = 1'b0; @(negedge clk);
        hblank = 1'b1; @(negedge clk);
        hblank = 1'b0;
        wait_idle();
        chk(log_n - b == 4, "R9", "edge during burst ignored", log_n - b, 4);
        b = log_n;
        pulse_hb(4);
        wait_idle();
        chk(log_n - b == 4, "R9", "held level fires once", log_n - b, 4);
        check_run(b, 4, 0, 24'h002004, 8'h20, 0, "R9");
        wr(0, 3, ctl(0, 0, 0, 0));
    endtask

    task automatic t_preempt();
        int b, n5, n1, first1, last5;
        setup(5, 24'h000100, 8'h55, 10);
        setup(1, 24'h000800, 8'h21, 1);
        wr(1, 3, ctl(1, 1, 1, 1));
        b = log_n;
        wr(5, 3, ctl(0, 0, 0, 1));
        repeat (3) @(negedge clk);
        pulse_hb(3);
        wait_idle();
        chk(log_n - b == 12, "R8", "total bytes", log_n - b, 12);
        n5 = 0; n1 = 0; first1 = -1; last5 = -1;
        for (int i = 0; i < log_n - b; i++) begin
            if (l_ch[b+i] == 3'd5) begin
                chk(l_ga[b+i] == 24'h000100 + 24'(n5), "R8", "resume address",
                    l_ga[b+i], 24'h000100 + 24'(n5));
                n5++; last5 = i;
            end else begin
                chk(l_ch[b+i] == 3'd1, "R8", "burst channel", l_ch[b+i], 1);
                chk(l_ga[b+i] == 24'h000800 + 24'(n1), "R8", "burst address",
                    l_ga[b+i], 24'h000800 + 24'(n1));
                chk(l_st[b+i] == 4'b0110, "R8", "burst strobes", l_st[b+i], 4'b0110);
                if (first1 < 0) first1 = i;
                n1++;
            end
        end
        chk(n5 == 10, "R8", "block bytes delivered", n5, 10);
        chk(n1 == 2, "R8", "burst bytes", n1, 2);
        chk(first1 > 0 && first1 < last5, "R8", "burst inside block run", first1, last5);
        wr(1, 3, ctl(0, 0, 0, 0));
    endtask

    task automatic t_zero();
        int b;
        setup(4, 24'h000010, 8'h44, 0);
        b = log_n;
        wr(4, 3, ctl(0, 0, 0, 1));
        wait_idle();
        chk(log_n - b == 65536, "R5", "zero count bytes", log_n - b, 65536);
        chk(last_ga == 24'h01000F, "R5", "last address", last_ga, 24'h01000F);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_dir_wrap();
        t_prio();
        t_hblank();
        t_ignore();
        t_preempt();
        t_zero();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule